// File: doc/BRIEF.md
# Data Access Translation and Fault Checker

This block is the address-check stage for loads and stores. Each cycle it may accept one access: a virtual address, a size, a store flag, a physical-mode flag, the processor's current privilege mode and the result of a translation-buffer lookup that happened outside the block. The lookup result is a hit flag, a page frame number, per-mode read and write enable masks, and two trap bits that force a fault on read or on write.

One cycle later the block returns either a physical address with an uncacheable flag, or a single fault kind with a status word. The block resolves several address sources:

- Physical-mode pass-through.
- A kernel-only direct-mapped window that takes the physical address from the virtual address.
- Normal page translation.

It then checks the result against the implemented physical space and folds the uncached I/O region. The checks follow a fixed priority, so exactly one fault is reported when several apply.

Top module: `dxlate_check`

## Requirements
- R1: `outValid` is high exactly one cycle after a cycle with `reqValid` high and is otherwise low. After reset `outValid`, `faultKind`, `mmStatus`, `physAddr` and `uncached` are all zero.
- R2: If the virtual address is not a multiple of 2^`sizeLog2` bytes, the fault is alignment (code 1) and beats every other check. Status bit 0 (write) is set for stores and nothing else is set.
- R3: With `physMode` high the physical address is the virtual address. The translation inputs (hit, frame, masks, trap bits) have no effect, and neither the address-validity check nor the direct window applies.
- R4: Outside physical mode, a virtual address whose bits 63:47 are not all equal gives a page fault (code 2). Its status has bit 3 (bad address) set, plus bit 0 on stores.
- R5: When virtual bits 47:41 equal 7'h7E the access uses the direct window and needs no translation hit. Any mode other than kernel (mode 0) gives an access violation (code 3) with status bit 2 set, plus bit 0 on stores.
- R6: A direct-window physical address is the low 44 virtual bits. If bit 40 is set, bits 43:40 are forced to one; otherwise bits 43:40 are cleared.
- R7: A translation miss gives a miss fault (code 4) with status bit 1 set, plus bit 0 on stores.
- R8: A store reads `wrEnMask` at the bit indexed by `cpuMode`:
  - A clear bit gives an access violation with status bits 0 and 2, plus bit 5 if `fonWrite` is set.
  - An allowed store with `fonWrite` set gives a page fault with status bits 0 and 5.
- R9: A load reads `rdEnMask` at the bit indexed by `cpuMode`:
  - A clear bit gives an access violation with status bit 2, plus bit 4 if `fonRead` is set.
  - An allowed load with `fonRead` set gives a page fault with status bit 4 alone.
- R10: A physical address (pass-through or translated) with any bit at or above bit 44 set gives a machine-check fault (code 5) with zero status. This check has the lowest priority.
- R11: A fault-free result with physical bit 43 set raises `uncached` and clears bits 42:35 of `physAddr`.
- R12: A faulted result drives `physAddr` to zero and `uncached` low. A fault-free result reports code 0 with zero status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access present this cycle |
| vaddr | input | VA_WIDTH | Virtual address |
| sizeLog2 | input | 2 | Access size as log2 of bytes |
| isWrite | input | 1 | High for stores |
| physMode | input | 1 | Bypass translation, address is physical |
| cpuMode | input | MODE_W | Current privilege mode, 0 is kernel |
| tlbHit | input | 1 | Translation lookup hit |
| tlbPpn | input | PPN_WIDTH | Page frame number from the lookup |
| rdEnMask | input | NUM_MODES | Read enable per mode |
| wrEnMask | input | NUM_MODES | Write enable per mode |
| fonRead | input | 1 | Trap-on-read bit of the entry |
| fonWrite | input | 1 | Trap-on-write bit of the entry |
| outValid | output | 1 | Result present |
| physAddr | output | PA_IMPL | Physical address, zero on a fault |
| uncached | output | 1 | Result lies in uncached space |
| faultKind | output | 3 | 0 none, 1 align, 2 page, 3 access, 4 miss, 5 machine check |
| mmStatus | output | 6 | Bits: 0 write, 1 miss, 2 access, 3 bad address, 4 read trap, 5 write trap |

## Verification
The bench uses the default parameters: a 64-bit virtual address checked for sign extension from bit 47, 44 implemented physical bits, 13-bit pages, a 32-bit frame number and four modes. With a 32-bit frame on 13-bit pages the translated address is 45 bits wide, so setting the top frame bit reaches the machine-check path through translation, as well as through physical mode. The vectors stack faults deliberately: misaligned bad addresses, and permitted accesses with a trap bit set. This shows that the priority order picks the right one.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_PAGE  = 3'd2,
    FLT_ACV   = 3'd3,
    FLT_MISS  = 3'd4,
    FLT_MCHK  = 3'd5
  } faultKind_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_MISS  = 1;
  localparam int ST_ACV   = 2;
  localparam int ST_BADVA = 3;
  localparam int ST_FONR  = 4;
  localparam int ST_FONW  = 5;

  typedef enum logic [1:0] {
    PATH_PHYS  = 2'd0,
    PATH_SUPER = 2'd1,
    PATH_TLB   = 2'd2
  } paPath_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    paPath_e path;
    logic    clean;
  } dpStrobe_t;

endpackage

// File: rtl/dxcDatapath.sv
module dxcDatapath
  import dxc_pkg::*;
#(
  parameter int VA_WIDTH    = 64,
  parameter int VA_SIGN_BIT = 47,
  parameter int PA_IMPL     = 44,
  parameter int PAGE_BITS   = 13,
  parameter int PPN_WIDTH   = 32,
  parameter int SP_TAG_LO   = 41,
  parameter int SP_EXT_BIT  = 40,
  parameter int UC_CLR_LO   = 35
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [VA_WIDTH-1:0]  vaddr,
  input  logic [1:0]           sizeLog2,
  input  logic [PPN_WIDTH-1:0] tlbPpn,
  input  dpStrobe_t            strobe,
  output logic                 aligned,
  output logic                 vaValid,
  output logic                 superWin,
  output logic                 physImplOk,
  output logic                 tlbImplOk,
  output logic [PA_IMPL-1:0]   physAddr,
  output logic                 uncached
);

  localparam int TAG_W   = VA_SIGN_BIT - SP_TAG_LO + 1;
  localparam logic [TAG_W-1:0] SP_TAG = {{(TAG_W-1){1'b1}}, 1'b0};
  localparam int TLB_W   = PPN_WIDTH + PAGE_BITS;
  localparam int UC_BIT  = PA_IMPL - 1;
  localparam int UC_CLR_HI = UC_BIT - 1;
  localparam logic [PA_IMPL-1:0] SP_LO_MASK  = (PA_IMPL'(1) << SP_EXT_BIT) - PA_IMPL'(1);
  localparam logic [PA_IMPL-1:0] SP_HI_ONES  = ~SP_LO_MASK;
  localparam logic [PA_IMPL-1:0] UC_CLR_MASK =
    (PA_IMPL'(1) << (UC_CLR_HI + 1)) - (PA_IMPL'(1) << UC_CLR_LO);

  logic [VA_WIDTH-1:0] sizeMask;
  logic [PA_IMPL-1:0]  superPa;
  logic [PA_IMPL-1:0]  tlbPa;
  logic [PA_IMPL-1:0]  selPa;
  logic [PA_IMPL-1:0]  foldedPa;
  logic [TLB_W-1:0]    tlbFull;
  logic                isUc;

  // alignment: low address bits under the size must be zero
  assign sizeMask = (VA_WIDTH'(1) << sizeLog2) - VA_WIDTH'(1);
  assign aligned  = ((vaddr & sizeMask) == '0);

  // canonical form: all bits above the sign bit copy it
  assign vaValid = (&vaddr[VA_WIDTH-1:VA_SIGN_BIT]) | ~(|vaddr[VA_WIDTH-1:VA_SIGN_BIT]);

  assign superWin = (vaddr[VA_SIGN_BIT:SP_TAG_LO] == SP_TAG);

  // direct window: extend the region above the extension bit
  always_comb begin
    if (vaddr[SP_EXT_BIT]) superPa = vaddr[PA_IMPL-1:0] | SP_HI_ONES;
    else                   superPa = vaddr[PA_IMPL-1:0] & SP_LO_MASK;
  end

  assign physImplOk = ~(|vaddr[VA_WIDTH-1:PA_IMPL]);

  assign tlbFull = {tlbPpn, vaddr[PAGE_BITS-1:0]};
  assign tlbPa   = tlbFull[PA_IMPL-1:0];

  generate
    if (TLB_W > PA_IMPL) begin : gWideFrame
      assign tlbImplOk = ~(|tlbFull[TLB_W-1:PA_IMPL]);
    end else begin : gNarrowFrame
      assign tlbImplOk = 1'b1;
    end
  endgenerate

  always_comb begin
    case (strobe.path)
      PATH_SUPER: selPa = superPa;
      PATH_TLB:   selPa = tlbPa;
      default:    selPa = vaddr[PA_IMPL-1:0];
    endcase
  end

  assign isUc     = selPa[UC_BIT];
  assign foldedPa = isUc ? (selPa & ~UC_CLR_MASK) : selPa;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physAddr <= '0;
      uncached <= 1'b0;
    end else if (strobe.capture && strobe.clean) begin
      physAddr <= foldedPa;
      uncached <= isUc;
    end else begin
      physAddr <= '0;
      uncached <= 1'b0;
    end
  end

endmodule

// File: rtl/dxcControl.sv
module dxcControl
  import dxc_pkg::*;
#(
  parameter int NUM_MODES = 4,
  parameter int MODE_W    = $clog2(NUM_MODES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 isWrite,
  input  logic                 physMode,
  input  logic [MODE_W-1:0]    cpuMode,
  input  logic                 tlbHit,
  input  logic [NUM_MODES-1:0] rdEnMask,
  input  logic [NUM_MODES-1:0] wrEnMask,
  input  logic                 fonRead,
  input  logic                 fonWrite,
  input  logic                 aligned,
  input  logic                 vaValid,
  input  logic                 superWin,
  input  logic                 physImplOk,
  input  logic                 tlbImplOk,
  output dpStrobe_t            strobe,
  output logic                 outValid,
  output logic [2:0]           faultKind,
  output logic [ST_W-1:0]      mmStatus
);

  localparam logic [MODE_W-1:0] KERNEL_MODE = '0;

  faultKind_e         nxtKind;
  logic [ST_W-1:0]    nxtSt;
  paPath_e            nxtPath;
  logic               modeWrOk;
  logic               modeRdOk;

  assign modeWrOk = wrEnMask[cpuMode];
  assign modeRdOk = rdEnMask[cpuMode];

  // fixed priority resolution
  always_comb begin
    nxtKind = FLT_NONE;
    nxtSt   = '0;
    nxtPath = PATH_PHYS;
    if (!aligned) begin
      nxtKind      = FLT_ALIGN;
      nxtSt[ST_WR] = isWrite;
    end else if (physMode) begin
      nxtPath = PATH_PHYS;
      if (!physImplOk) nxtKind = FLT_MCHK;
    end else if (!vaValid) begin
      nxtKind         = FLT_PAGE;
      nxtSt[ST_WR]    = isWrite;
      nxtSt[ST_BADVA] = 1'b1;
    end else if (superWin) begin
      nxtPath = PATH_SUPER;
      if (cpuMode != KERNEL_MODE) begin
        nxtKind       = FLT_ACV;
        nxtSt[ST_WR]  = isWrite;
        nxtSt[ST_ACV] = 1'b1;
      end
    end else if (!tlbHit) begin
      nxtKind        = FLT_MISS;
      nxtSt[ST_WR]   = isWrite;
      nxtSt[ST_MISS] = 1'b1;
    end else begin
      nxtPath = PATH_TLB;
      if (isWrite && !modeWrOk) begin
        nxtKind        = FLT_ACV;
        nxtSt[ST_WR]   = 1'b1;
        nxtSt[ST_ACV]  = 1'b1;
        nxtSt[ST_FONW] = fonWrite;
      end else if (isWrite && fonWrite) begin
        nxtKind        = FLT_PAGE;
        nxtSt[ST_WR]   = 1'b1;
        nxtSt[ST_FONW] = 1'b1;
      end else if (!isWrite && !modeRdOk) begin
        nxtKind        = FLT_ACV;
        nxtSt[ST_ACV]  = 1'b1;
        nxtSt[ST_FONR] = fonRead;
      end else if (!isWrite && fonRead) begin
        nxtKind        = FLT_PAGE;
        nxtSt[ST_FONR] = 1'b1;
      end else if (!tlbImplOk) begin
        nxtKind = FLT_MCHK;
      end
    end
  end

  assign strobe.capture = reqValid;
  assign strobe.path    = nxtPath;
  assign strobe.clean   = (nxtKind == FLT_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      faultKind <= 3'd0;
      mmStatus  <= '0;
    end else begin
      outValid  <= reqValid;
      faultKind <= reqValid ? nxtKind : FLT_NONE;
      mmStatus  <= reqValid ? nxtSt : '0;
    end
  end

endmodule

// File: rtl/dxlate_check.sv
module dxlate_check
  import dxc_pkg::*;
#(
  parameter int VA_WIDTH    = 64,
  parameter int VA_SIGN_BIT = 47,
  parameter int PA_IMPL     = 44,
  parameter int PAGE_BITS   = 13,
  parameter int PPN_WIDTH   = 32,
  parameter int NUM_MODES   = 4,
  parameter int MODE_W      = $clog2(NUM_MODES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [VA_WIDTH-1:0]  vaddr,
  input  logic [1:0]           sizeLog2,
  input  logic                 isWrite,
  input  logic                 physMode,
  input  logic [MODE_W-1:0]    cpuMode,
  input  logic                 tlbHit,
  input  logic [PPN_WIDTH-1:0] tlbPpn,
  input  logic [NUM_MODES-1:0] rdEnMask,
  input  logic [NUM_MODES-1:0] wrEnMask,
  input  logic                 fonRead,
  input  logic                 fonWrite,
  output logic                 outValid,
  output logic [PA_IMPL-1:0]   physAddr,
  output logic                 uncached,
  output logic [2:0]           faultKind,
  output logic [5:0]           mmStatus
);

  dpStrobe_t strobe;
  logic aligned, vaValid, superWin, physImplOk, tlbImplOk;

  dxcDatapath #(
    .VA_WIDTH(VA_WIDTH), .VA_SIGN_BIT(VA_SIGN_BIT), .PA_IMPL(PA_IMPL),
    .PAGE_BITS(PAGE_BITS), .PPN_WIDTH(PPN_WIDTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .vaddr(vaddr), .sizeLog2(sizeLog2),
    .tlbPpn(tlbPpn), .strobe(strobe), .aligned(aligned), .vaValid(vaValid),
    .superWin(superWin), .physImplOk(physImplOk), .tlbImplOk(tlbImplOk),
    .physAddr(physAddr), .uncached(uncached)
  );

  dxcControl #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isWrite(isWrite),
    .physMode(physMode), .cpuMode(cpuMode), .tlbHit(tlbHit),
    .rdEnMask(rdEnMask), .wrEnMask(wrEnMask), .fonRead(fonRead),
    .fonWrite(fonWrite), .aligned(aligned), .vaValid(vaValid),
    .superWin(superWin), .physImplOk(physImplOk), .tlbImplOk(tlbImplOk),
    .strobe(strobe), .outValid(outValid), .faultKind(faultKind),
    .mmStatus(mmStatus)
  );

endmodule

// File: rtl/dxlate_check_chk.sv
module dxlate_check_chk #(
  parameter int PA_IMPL = 44
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               isWrite,
  input logic               outValid,
  input logic [PA_IMPL-1:0] physAddr,
  input logic               uncached,
  input logic [2:0]         faultKind,
  input logic [5:0]         mmStatus
);

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);  // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && faultKind == 3'd0 && mmStatus == 6'd0));  // R1

  AST_LOAD_NO_WR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isWrite) |=> !mmStatus[0]);  // R9

  AST_MISS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (mmStatus[1] == (faultKind == 3'd4)));  // R7

  AST_BADVA_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    mmStatus[3] |-> (faultKind == 3'd2));  // R4

  AST_MCHK_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (faultKind == 3'd5) |-> (mmStatus == 6'd0));  // R10

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rstN)
    (faultKind != 3'd0) |-> (physAddr == '0 && !uncached));  // R12

  AST_UC_FOLDED: assert property (@(posedge clk) disable iff (!rstN)
    uncached |-> (physAddr[PA_IMPL-1] && physAddr[PA_IMPL-2:35] == '0));  // R11

  AST_CACHED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !uncached) |-> !physAddr[PA_IMPL-1]);  // R11

endmodule

bind dxlate_check dxlate_check_chk #(.PA_IMPL(PA_IMPL)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .isWrite(isWrite),
  .outValid(outValid), .physAddr(physAddr), .uncached(uncached),
  .faultKind(faultKind), .mmStatus(mmStatus)
);

// File: tb/dxlate_check_test.sv
module dxlate_check_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  sz;
    logic        wr;
    logic        ph;
    logic [1:0]  md;
    logic        hit;
    logic [31:0] ppn;
    logic [3:0]  rdEn;
    logic [3:0]  wrEn;
    logic        fr;
    logic        fw;
    logic [2:0]  eKind;
    logic [5:0]  eSt;
    logic [43:0] ePa;
    logic        eUc;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R3 physical load, translation inputs idle
    '{64'h0000_0000_1234_5678, 2'd3, 1'b0, 1'b1, 2'd3, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 3'd0, 6'h00, 44'h000_1234_5678, 1'b0, 8'd3},
    // R2 misaligned store
    '{64'h0000_0000_0000_1002, 2'd2, 1'b1, 1'b0, 2'd0, 1'b1, 32'h0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd1, 6'h01, 44'h0, 1'b0, 8'd2},
    // R2 alignment beats bad address
    '{64'h8000_0000_0000_0001, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 3'd1, 6'h00, 44'h0, 1'b0, 8'd2},
    // R4 non-canonical store
    '{64'h0001_0000_0000_0000, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 32'h0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd2, 6'h09, 44'h0, 1'b0, 8'd4},
    // R6 direct window with bit 40 set, folded uncached
    '{64'hFFFF_FD00_0000_1000, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 3'd0, 6'h00, 44'h800_0000_1000, 1'b1, 8'd6},
    // R6 direct window, bit 40 clear
    '{64'hFFFF_FC12_3456_7000, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 3'd0, 6'h00, 44'h012_3456_7000, 1'b0, 8'd6},
    // R5 direct window from user mode store
    '{64'hFFFF_FC12_3456_7000, 2'd3, 1'b1, 1'b0, 2'd3, 1'b1, 32'h0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd3, 6'h05, 44'h0, 1'b0, 8'd5},
    // R7 miss on load
    '{64'h0000_0000_0040_2000, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd4, 6'h02, 44'h0, 1'b0, 8'd7},
    // R7 miss on store
    '{64'h0000_0000_0040_2000, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0, 4'hF, 4'hF, 1'b0, 1'b0, 3'd4, 6'h03, 44'h0, 1'b0, 8'd7},
    // R9 permitted user load
    '{64'h0000_0000_0040_2ABC, 2'd0, 1'b0, 1'b0, 2'd3, 1'b1, 32'h0001_2345, 4'b1000, 4'b0000, 1'b0, 1'b1, 3'd0, 6'h00, 44'h000_2468_AABC, 1'b0, 8'd9},
    // R9 load denied in mode 1 with read trap
    '{64'h0000_0000_0040_2ABC, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 32'h0001_2345, 4'b1000, 4'b1111, 1'b1, 1'b0, 3'd3, 6'h14, 44'h0, 1'b0, 8'd9},
    // R9 load permitted but read trap
    '{64'h0000_0000_0040_2ABC, 2'd0, 1'b0, 1'b0, 2'd3, 1'b1, 32'h0001_2345, 4'b1000, 4'b0000, 1'b1, 1'b0, 3'd2, 6'h10, 44'h0, 1'b0, 8'd9},
    // R8 store denied in mode 2 with write trap
    '{64'h0000_0000_0040_2ABC, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1, 32'h0001_2345, 4'b1111, 4'b0001, 1'b0, 1'b1, 3'd3, 6'h25, 44'h0, 1'b0, 8'd8},
    // R8 store permitted but write trap
    '{64'h0000_0000_0040_2ABC, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1, 32'h0001_2345, 4'b0000, 4'b1111, 1'b0, 1'b1, 3'd2, 6'h21, 44'h0, 1'b0, 8'd8},
    // R8 permitted store, read trap and read mask ignored
    '{64'h0000_0000_0040_2ABC, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1, 32'h0001_2345, 4'b0000, 4'b0100, 1'b1, 1'b0, 3'd0, 6'h00, 44'h000_2468_AABC, 1'b0, 8'd8},
    // R10 translated frame beyond implemented space
    '{64'h0000_0000_0040_2000, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 32'h8000_0000, 4'hF, 4'hF, 1'b0, 1'b0, 3'd5, 6'h00, 44'h0, 1'b0, 8'd10},
    // R10 physical address beyond implemented space
    '{64'h0004_0000_0000_0000, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 3'd5, 6'h00, 44'h0, 1'b0, 8'd10},
    // R11 physical uncached fold
    '{64'h0000_0FFF_FFFF_FFF8, 2'd3, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 3'd0, 6'h00, 44'h807_FFFF_FFF8, 1'b1, 8'd11},
    // R3 physical mode: trap bits, masks and window tag ignored, no miss
    '{64'h0000_0000_0000_0040, 2'd3, 1'b1, 1'b1, 2'd3, 1'b0, 32'hFFFF_FFFF, 4'h0, 4'h0, 1'b1, 1'b1, 3'd0, 6'h00, 44'h000_0000_0040, 1'b0, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [63:0] vaddr;
  logic [1:0]  sizeLog2;
  logic        isWrite, physMode, tlbHit, fonRead, fonWrite;
  logic [1:0]  cpuMode;
  logic [31:0] tlbPpn;
  logic [3:0]  rdEnMask, wrEnMask;
  logic        outValid, uncached;
  logic [43:0] physAddr;
  logic [2:0]  faultKind;
  logic [5:0]  mmStatus;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dxlate_check uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr),
    .sizeLog2(sizeLog2), .isWrite(isWrite), .physMode(physMode),
    .cpuMode(cpuMode), .tlbHit(tlbHit), .tlbPpn(tlbPpn),
    .rdEnMask(rdEnMask), .wrEnMask(wrEnMask), .fonRead(fonRead),
    .fonWrite(fonWrite), .outValid(outValid), .physAddr(physAddr),
    .uncached(uncached), .faultKind(faultKind), .mmStatus(mmStatus)
  );

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    reqValid = 1'b1; vaddr = v.va; sizeLog2 = v.sz; isWrite = v.wr;
    physMode = v.ph; cpuMode = v.md; tlbHit = v.hit; tlbPpn = v.ppn;
    rdEnMask = v.rdEn; wrEnMask = v.wrEn; fonRead = v.fr; fonWrite = v.fw;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; vaddr = '0; sizeLog2 = '0; isWrite = 1'b0;
    physMode = 1'b0; cpuMode = '0; tlbHit = 1'b0; tlbPpn = '0;
    rdEnMask = '0; wrEnMask = '0; fonRead = 1'b0; fonWrite = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset outValid", 64'(outValid), 64'd0);
    check("R1 reset faultKind", 64'(faultKind), 64'd0);
    check("R1 reset physAddr/uncached", 64'({uncached, physAddr}), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // vector table, one access per cycle
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      applyVec(VECS[i]);
      @(posedge clk);
      #1;
      if ({outValid, faultKind, mmStatus, physAddr, uncached} !==
          {1'b1, VECS[i].eKind, VECS[i].eSt, VECS[i].ePa, VECS[i].eUc}) begin
        nFails++;
        $display("FAIL R%0d vec %0d actual v=%b k=%0d st=%h pa=%h uc=%b expected v=1 k=%0d st=%h pa=%h uc=%b",
                 VECS[i].req, i, outValid, faultKind, mmStatus, physAddr, uncached,
                 VECS[i].eKind, VECS[i].eSt, VECS[i].ePa, VECS[i].eUc);
      end
      nChecks++;
    end

    // R1 idle cycle clears result
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    check("R1 idle outValid", 64'(outValid), 64'd0);
    check("R12 idle physAddr", 64'(physAddr), 64'd0);

    // R12 fault after an uncached result zeroes address and flag
    @(negedge clk);
    applyVec(VECS[17]);
    @(posedge clk);
    #1;
    check("R11 uncached set", 64'(uncached), 64'd1);
    @(negedge clk);
    applyVec(VECS[7]);
    @(posedge clk);
    #1;
    check("R12 fault zeroes uncached", 64'(uncached), 64'd0);
    check("R12 fault zeroes physAddr", 64'(physAddr), 64'd0);

    // R2 every size boundary: 8-byte load at offset 4 misaligned
    @(negedge clk);
    applyVec(VECS[0]);
    vaddr = 64'h0000_0000_0000_0104;
    @(posedge clk);
    #1;
    check("R2 8-byte at offset 4", 64'(faultKind), 64'd1);
    @(negedge clk);
    sizeLog2 = 2'd2;
    @(posedge clk);
    #1;
    check("R2 4-byte at offset 4 ok", 64'(faultKind), 64'd0);

    // R1 reset mid-stream clears outputs
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    check("R1 reset clears outValid", 64'(outValid), 64'd0);

    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b1;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule